// File: doc/BRIEF.md
# Media Engine Reset Sequencer with Shared Scaler Ownership

This block runs the reset of a chosen set of media engines when some of those engines share scaler units. A request brings a bitmask of engines. For each engine that can reach a shared unit, the sequencer asserts a forced-lock line. It then waits for the arbiter to acknowledge that ownership of the unit is frozen. If the engine turns out to own its unit, the sequencer adds that unit's reset bit to the domain mask. Once every engine has been visited, it issues a one-cycle domain-reset strobe together with the combined mask. It waits for the reset to complete, clears the forced locks of every requested engine and pulses done.

A whole-device request skips all locking. It strobes a mask that holds only the full-domain bit, waits for completion and finishes.

Engines are numbered with the decode engines first (indices 0 to N_DEC-1), followed by the enhancement engines. The domain bit positions are parameters. By default, decode engine i maps to bit 5+i, enhancement engine j to bit 13+j, shared unit k to bit 17+k, and the full domain to bit 0.

The states are IDLE, SCAN, LOCK_WAIT, FIRE, WAIT_DONE, UNLOCK and FINISH. Their transitions are:
- IDLE→FIRE on a full request.
- IDLE→SCAN on a partial request.
- SCAN→LOCK_WAIT when the current engine is requested and eligible.
- SCAN→SCAN otherwise, moving to the next index.
- SCAN→FIRE after the last index.
- LOCK_WAIT→SCAN on acknowledge or on timeout.
- FIRE→WAIT_DONE always.
- WAIT_DONE→UNLOCK on completion of a partial request.
- WAIT_DONE→FINISH on completion of a full request.
- UNLOCK→FINISH always.
- FINISH→IDLE always.

Top module: `media_reset_seq`

## Requirements
- R1: After reset, force_lock, dom_mask, dom_strobe, seq_done and ack_timeout are all zero.
- R2: A request with req_full=1 strobes a dom_mask that has only bit 0 set. It never asserts any force_lock bit, and seq_done follows one cycle after the cycle in which reset_done is seen.
- R3: For a partial request, dom_mask holds bit 5+i for each requested decode engine i and bit 13+j for each requested enhancement engine j (engine index 4+j).
- R4: Forced locks are raised one engine at a time, in ascending engine index order.
- R5: When an acknowledge arrives while unit_owned is high, the unit bit is added to the mask. For decode engine N that bit is 17+(N>>1); for enhancement engine N it is 17+N.
- R6: A decode engine whose dec_shared_mask bit is 0 never has its force_lock bit set and adds no unit bit. Every requested enhancement engine is locked.
- R7: If lock_ack does not arrive within TIMEOUT cycles of LOCK_WAIT, the engine adds no unit bit, ack_timeout is set and the walk continues. An acknowledge in the last allowed cycle still counts. ack_timeout stays set until the next request is accepted.
- R8: An acknowledge with unit_owned low adds no unit bit.
- R9: dom_strobe is high for exactly one cycle. All forced locks stay asserted while the sequencer waits for reset_done.
- R10: After reset_done, the force_lock bits of all requested engines are cleared, including engines that timed out, and seq_done is high for exactly one cycle.
- R11: A req_valid that arrives while a sequence is in progress is ignored and starts no further sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a sequence (accepted only in IDLE) |
| req_full | input | 1 | Whole-device reset, no locking |
| req_engines | input | N_DEC+N_ENH | Engines to reset, decode engines first |
| dec_shared_mask | input | N_DEC | Decode engines that can reach a shared unit |
| lock_ack | input | N_DEC+N_ENH | Arbiter confirms ownership is frozen |
| unit_owned | input | N_DEC+N_ENH | Engine owns its shared unit |
| reset_done | input | 1 | Domain reset has completed |
| force_lock | output | N_DEC+N_ENH | Forced-lock request per engine |
| dom_mask | output | DOM_W | Combined reset-domain mask |
| dom_strobe | output | 1 | One-cycle domain reset pulse |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| ack_timeout | output | 1 | Sticky: some acknowledge timed out |

## Verification
Random engine masks are combined with random shared-access masks, acknowledge delays and ownership bits. This separates the per-engine domain bits from the unit bits that come from ownership, and it shows that unshared decode engines are skipped. Directed cases cover the following:
- Decode engines 2 and 3, which both fold into unit bit 18.
- An acknowledge in the last allowed cycle, set against one a cycle later, which pins down the timeout edge.
- A timed-out engine, to show that its lock is still released.
- A full request, to show that it bypasses locking and clears a sticky timeout.
- A request injected mid-sequence, to show that it leaves no trace.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_LOCK_WAIT,
        S_FIRE,
        S_WAIT_DONE,
        S_UNLOCK,
        S_FINISH
    } seq_state_t;

    localparam int DEF_N_DEC     = 4;
    localparam int DEF_N_ENH     = 2;
    localparam int DEF_DOM_W     = 32;
    localparam int DEF_TIMEOUT   = 1000;
    localparam int DEF_FULL_BIT  = 0;
    localparam int DEF_DEC_BASE  = 5;
    localparam int DEF_ENH_BASE  = 13;
    localparam int DEF_UNIT_BASE = 17;

endpackage

// File: rtl/mrs_domain_map.sv
module mrs_domain_map #(
    parameter int N_DEC     = 4,
    parameter int N_ENH     = 2,
    parameter int DOM_W     = 32,
    parameter int DEC_BASE  = 5,
    parameter int ENH_BASE  = 13,
    parameter int UNIT_BASE = 17,
    localparam int N_ENG    = N_DEC + N_ENH
) (
    input  logic [N_ENG-1:0]            eng_mask,
    input  logic [N_DEC-1:0]            shared_mask,
    output logic [DOM_W-1:0]            eng_dom,
    output logic [N_ENG-1:0]            eligible,
    output logic [N_ENG-1:0][DOM_W-1:0] unit_dom
);

    logic [N_ENG-1:0][DOM_W-1:0] parts;

    // Decode engines: two instances share one unit
    for (genvar d = 0; d < N_DEC; d++) begin : g_dec
        localparam int EB = DEC_BASE + d;
        localparam int UB = UNIT_BASE + (d >> 1);
        assign parts[d]    = eng_mask[d] ? (DOM_W'(1) << EB) : '0;
        assign unit_dom[d] = DOM_W'(1) << UB;
        assign eligible[d] = shared_mask[d];
    end

    // Enhancement engines: one unit each, always eligible
    for (genvar e = 0; e < N_ENH; e++) begin : g_enh
        localparam int EB = ENH_BASE + e;
        localparam int UB = UNIT_BASE + e;
        assign parts[N_DEC+e]    = eng_mask[N_DEC+e] ? (DOM_W'(1) << EB) : '0;
        assign unit_dom[N_DEC+e] = DOM_W'(1) << UB;
        assign eligible[N_DEC+e] = 1'b1;
    end

    always_comb begin
        eng_dom = '0;
        for (int i = 0; i < N_ENG; i++) begin
            eng_dom = eng_dom | parts[i];
        end
    end

endmodule

// File: rtl/mrs_ack_timer.sv
module mrs_ack_timer #(
    parameter int TIMEOUT = 1000,
    localparam int CW     = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = run && (cnt == CW'(TIMEOUT - 1));

endmodule

// File: rtl/media_reset_seq.sv
module media_reset_seq
    import mrs_pkg::*;
#(
    parameter int N_DEC     = DEF_N_DEC,
    parameter int N_ENH     = DEF_N_ENH,
    parameter int DOM_W     = DEF_DOM_W,
    parameter int TIMEOUT   = DEF_TIMEOUT,
    parameter int FULL_BIT  = DEF_FULL_BIT,
    parameter int DEC_BASE  = DEF_DEC_BASE,
    parameter int ENH_BASE  = DEF_ENH_BASE,
    parameter int UNIT_BASE = DEF_UNIT_BASE,
    localparam int N_ENG    = N_DEC + N_ENH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_full,
    input  logic [N_ENG-1:0] req_engines,
    input  logic [N_DEC-1:0] dec_shared_mask,
    input  logic [N_ENG-1:0] lock_ack,
    input  logic [N_ENG-1:0] unit_owned,
    input  logic             reset_done,
    output logic [N_ENG-1:0] force_lock,
    output logic [DOM_W-1:0] dom_mask,
    output logic             dom_strobe,
    output logic             seq_done,
    output logic             ack_timeout
);

    localparam int IW   = $clog2(N_ENG + 1);
    localparam int PADN = 2 ** IW;

    seq_state_t state, state_nx;

    logic [IW-1:0]    idx;
    logic [N_ENG-1:0] mask_r;
    logic [N_ENG-1:0] lock_r;
    logic [DOM_W-1:0] dom_r;
    logic             full_r;
    logic             timeout_r;

    logic [DOM_W-1:0]            eng_dom;
    logic [N_ENG-1:0]            eligible;
    logic [N_ENG-1:0][DOM_W-1:0] unit_dom;
    logic                        expired;

    logic [PADN-1:0]            hit_pad, ack_pad, own_pad, sel_onehot;
    logic [PADN-1:0][DOM_W-1:0] unit_pad;
    logic                       at_end;

    mrs_domain_map #(
        .N_DEC    (N_DEC),
        .N_ENH    (N_ENH),
        .DOM_W    (DOM_W),
        .DEC_BASE (DEC_BASE),
        .ENH_BASE (ENH_BASE),
        .UNIT_BASE(UNIT_BASE)
    ) u_map (
        .eng_mask   (req_engines),
        .shared_mask(dec_shared_mask),
        .eng_dom    (eng_dom),
        .eligible   (eligible),
        .unit_dom   (unit_dom)
    );

    mrs_ack_timer #(
        .TIMEOUT(TIMEOUT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == S_LOCK_WAIT),
        .expired(expired)
    );

    // Per-index views padded to a power of two so idx never selects out of range
    always_comb begin
        hit_pad  = PADN'(mask_r & eligible);
        ack_pad  = PADN'(lock_ack);
        own_pad  = PADN'(unit_owned);
        unit_pad = '0;
        for (int i = 0; i < N_ENG; i++) begin
            unit_pad[i] = unit_dom[i];
        end
        sel_onehot = PADN'(1) << idx;
        at_end     = (idx == IW'(N_ENG));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    state_nx = req_full ? S_FIRE : S_SCAN;
                end
            end
            S_SCAN: begin
                if (at_end) begin
                    state_nx = S_FIRE;
                end else if (hit_pad[idx]) begin
                    state_nx = S_LOCK_WAIT;
                end
            end
            S_LOCK_WAIT: begin
                if (ack_pad[idx] || expired) begin
                    state_nx = S_SCAN;
                end
            end
            S_FIRE:      state_nx = S_WAIT_DONE;
            S_WAIT_DONE: begin
                if (reset_done) begin
                    state_nx = full_r ? S_FINISH : S_UNLOCK;
                end
            end
            S_UNLOCK:    state_nx = S_FINISH;
            S_FINISH:    state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // Sequence datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            mask_r    <= '0;
            lock_r    <= '0;
            dom_r     <= '0;
            full_r    <= 1'b0;
            timeout_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        mask_r    <= req_engines;
                        full_r    <= req_full;
                        timeout_r <= 1'b0;
                        idx       <= '0;
                        dom_r     <= req_full ? (DOM_W'(1) << FULL_BIT) : eng_dom;
                    end
                end
                S_SCAN: begin
                    if (!at_end) begin
                        if (hit_pad[idx]) begin
                            lock_r <= lock_r | sel_onehot[N_ENG-1:0];
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end
                end
                S_LOCK_WAIT: begin
                    if (ack_pad[idx]) begin
                        if (own_pad[idx]) begin
                            dom_r <= dom_r | unit_pad[idx];
                        end
                        idx <= idx + IW'(1);
                    end else if (expired) begin
                        timeout_r <= 1'b1;
                        idx       <= idx + IW'(1);
                    end
                end
                S_UNLOCK: begin
                    lock_r <= lock_r & ~mask_r;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        force_lock  = lock_r;
        dom_mask    = dom_r;
        ack_timeout = timeout_r;
        dom_strobe  = (state == S_FIRE);
        seq_done    = (state == S_FINISH);
    end

endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
    parameter int N_DEC    = 4,
    parameter int N_ENH    = 2,
    parameter int DOM_W    = 32,
    parameter int FULL_BIT = 0,
    localparam int N_ENG   = N_DEC + N_ENH
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEC-1:0] dec_shared_mask,
    input logic [N_ENG-1:0] force_lock,
    input logic [DOM_W-1:0] dom_mask,
    input logic             dom_strobe,
    input logic             seq_done
);

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        dom_strobe |=> !dom_strobe);

    a_r4_one_lock_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(force_lock & ~$past(force_lock)) <= 1);

    a_r2_full_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_strobe && dom_mask[FULL_BIT]) |-> (force_lock == '0));

    a_r6_no_lock_unshared: assert property (@(posedge clk) disable iff (!rst_n)
        (force_lock[N_DEC-1:0] & ~dec_shared_mask) == '0);

    a_r10_done_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (force_lock == '0));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    a_r9_no_strobe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(dom_strobe && seq_done));

endmodule

bind media_reset_seq mrs_checker #(
    .N_DEC   (N_DEC),
    .N_ENH   (N_ENH),
    .DOM_W   (DOM_W),
    .FULL_BIT(FULL_BIT)
) u_mrs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_shared_mask(dec_shared_mask),
    .force_lock     (force_lock),
    .dom_mask       (dom_mask),
    .dom_strobe     (dom_strobe),
    .seq_done       (seq_done)
);

// File: tb/media_reset_seq_bench.sv
module media_reset_seq_bench;

    localparam int TO = 24;
    localparam int ND = 4;
    localparam int NE = 2;
    localparam int NG = ND + NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_full = 1'b0;
    logic [NG-1:0] req_engines = '0;
    logic [ND-1:0] dec_shared_mask = '0;
    logic [NG-1:0] lock_ack;
    logic [NG-1:0] unit_owned = '0;
    logic          reset_done = 1'b0;
    logic [NG-1:0] force_lock;
    logic [31:0]   dom_mask;
    logic          dom_strobe;
    logic          seq_done;
    logic          ack_timeout;

    int checks = 0;
    int errors = 0;
    int dly [NG];
    int acnt [NG];
    int last_idx;
    int order_err;
    logic [NG-1:0] prev_fl = '0;

    always #5 clk = ~clk;

    media_reset_seq #(.TIMEOUT(TO)) u_media_reset_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_full(req_full),
        .req_engines(req_engines), .dec_shared_mask(dec_shared_mask),
        .lock_ack(lock_ack), .unit_owned(unit_owned), .reset_done(reset_done),
        .force_lock(force_lock), .dom_mask(dom_mask), .dom_strobe(dom_strobe),
        .seq_done(seq_done), .ack_timeout(ack_timeout)
    );

    // Arbiter model: acknowledge once a lock has been held dly cycles
    always @(posedge clk) begin
        for (int e = 0; e < NG; e++) begin
            if (!force_lock[e]) acnt[e] <= 0;
            else if (acnt[e] < 4000) acnt[e] <= acnt[e] + 1;
        end
    end
    always_comb begin
        for (int e = 0; e < NG; e++) lock_ack[e] = force_lock[e] && (acnt[e] >= dly[e]);
    end

    // Ordering monitor for R4
    always @(negedge clk) begin
        logic [NG-1:0] rises;
        rises = force_lock & ~prev_fl;
        if (rises != '0) begin
            if ($countones(rises) != 1) order_err++;
            for (int e = 0; e < NG; e++) begin
                if (rises[e]) begin
                    if (e <= last_idx) order_err++;
                    last_idx = e;
                end
            end
        end
        prev_fl = force_lock;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit elig(input int e);
        return (e >= ND) ? 1'b1 : dec_shared_mask[e];
    endfunction

    function automatic logic [31:0] exp_mask(input logic [NG-1:0] m, input bit full);
        logic [31:0] r;
        r = '0;
        if (full) return 32'h1;
        for (int d = 0; d < ND; d++) if (m[d]) begin
            r[5+d] = 1'b1;
            if (elig(d) && dly[d] < TO && unit_owned[d]) r[17 + d/2] = 1'b1;
        end
        for (int j = 0; j < NE; j++) if (m[ND+j]) begin
            r[13+j] = 1'b1;
            if (dly[ND+j] < TO && unit_owned[ND+j]) r[17+j] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [NG-1:0] exp_lock(input logic [NG-1:0] m, input bit full);
        logic [NG-1:0] r;
        r = '0;
        if (!full) for (int e = 0; e < NG; e++) r[e] = m[e] && elig(e);
        return r;
    endfunction

    function automatic bit exp_to(input logic [NG-1:0] m, input bit full);
        bit t;
        t = 1'b0;
        if (!full) for (int e = 0; e < NG; e++) if (m[e] && elig(e) && dly[e] >= TO) t = 1'b1;
        return t;
    endfunction

    task automatic run_seq(input logic [NG-1:0] m, input bit full, input bit inject);
        logic [31:0] em;
        logic [NG-1:0] el;
        bit et;
        int n;
        bit saw;
        em = exp_mask(m, full);
        el = exp_lock(m, full);
        et = exp_to(m, full);
        last_idx = -1;
        order_err = 0;
        @(negedge clk);
        req_valid = 1'b1; req_engines = m; req_full = full;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!dom_strobe && n < 2000) begin @(negedge clk); n++; end
        chk(dom_strobe, "R9 strobe seen", 64'(dom_strobe), 64'd1);
        chk(dom_mask == em, full ? "R2 full mask" : "R3/R5/R8 domain mask", 64'(dom_mask), 64'(em));
        chk(force_lock == el, "R6 locks at strobe", 64'(force_lock), 64'(el));
        @(negedge clk);
        chk(!dom_strobe, "R9 strobe one cycle", 64'(dom_strobe), 64'd0);
        if (inject) begin
            req_valid = 1'b1; req_engines = ~m; req_full = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(force_lock == el, "R9 locks held while waiting", 64'(force_lock), 64'(el));
        reset_done = 1'b1;
        @(negedge clk);
        reset_done = 1'b0;
        n = 1;
        while (!seq_done && n < 5) begin @(negedge clk); n++; end
        chk(n == (full ? 1 : 2), full ? "R2 done latency" : "R10 done latency", 64'(n), full ? 64'd1 : 64'd2);
        chk(force_lock == '0, "R10 all locks released", 64'(force_lock), 64'd0);
        chk(ack_timeout == et, "R7 timeout flag", 64'(ack_timeout), 64'(et));
        @(negedge clk);
        chk(!seq_done, "R10 done one cycle", 64'(seq_done), 64'd0);
        chk(ack_timeout == et, "R7 timeout sticky", 64'(ack_timeout), 64'(et));
        chk(order_err == 0, "R4 lock order", 64'(order_err), 64'd0);
        if (inject) begin
            saw = 1'b0;
            repeat (6) begin @(negedge clk); saw |= dom_strobe | (force_lock != '0); end
            chk(!saw, "R11 mid-sequence request ignored", 64'(saw), 64'd0);
        end
    endtask

    task automatic rand_cfg();
        for (int e = 0; e < NG; e++) begin
            case ($urandom % 4)
                0: dly[e] = $urandom % 4;
                1: dly[e] = $urandom % TO;
                2: dly[e] = TO + 5 + ($urandom % 8);
                default: dly[e] = $urandom % 2;
            endcase
        end
        unit_owned = NG'($urandom);
        dec_shared_mask = ND'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < NG; e++) dly[e] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(force_lock == '0 && dom_mask == '0 && !dom_strobe && !seq_done && !ack_timeout,
            "R1 reset state", {force_lock, dom_mask, dom_strobe, seq_done, ack_timeout}, 64'd0);

        // R5: decode 2 and 3 share unit bit 18, enhancement 1 also bit 18
        dec_shared_mask = 4'b1111; unit_owned = 6'b001100;
        run_seq(6'b001100, 1'b0, 1'b0);
        unit_owned = 6'b100000;
        run_seq(6'b100000, 1'b0, 1'b0);
        // R8: acknowledged but not owned
        unit_owned = '0;
        run_seq(6'b111111, 1'b0, 1'b0);
        // R6: unshared decode engines skipped
        dec_shared_mask = 4'b0101; unit_owned = 6'b111111;
        run_seq(6'b111111, 1'b0, 1'b1);
        // R7: ack in last allowed cycle vs one cycle late
        dec_shared_mask = 4'b1111; unit_owned = 6'b111111;
        dly[0] = TO - 1; dly[4] = TO;
        run_seq(6'b010001, 1'b0, 1'b0);
        // R2: full request clears sticky timeout and never locks
        run_seq(6'b111111, 1'b1, 1'b1);
        for (int e = 0; e < NG; e++) dly[e] = 0;
        run_seq(6'b000000, 1'b0, 1'b0);

        for (int k = 0; k < 40; k++) begin
            rand_cfg();
            run_seq(NG'($urandom), ($urandom % 8) == 0, ($urandom % 3) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule